// File: doc/BRIEF.md
# Image Sensor Command Interpreter and Configuration Registers

This block sits between the byte receiver of a linear image sensor's serial port and the rest of the sensor logic. Every accepted byte is classified either as a one-byte action opcode, as the first byte of a two-byte register write, or as a register read. Action opcodes become single-cycle pulses toward the readout sequencer: main reset, start integration, sample, read pixels, and abort. Combined opcodes raise several of these pulses in the same cycle. The block holds a per-zone offset and gain for each of the three pixel zones, plus a mode register whose sleep bit is driven out to the analog section.

A register read captures the addressed value when the read opcode arrives. The value is handed to the output transmitter on a fixed delay, as a parallel byte whose bit 0 is the first bit sent on the line. A one-cycle interface-reset input, raised by the receiver when it detects a break, returns the interpreter to waiting for an opcode. The interpreter has two named states. ST_OPCODE means the next byte is an opcode. ST_WDATA means the next byte is write data. The transitions are: ST_OPCODE to ST_WDATA on a write opcode; ST_WDATA to ST_OPCODE on any accepted byte; and either state to ST_OPCODE on interface reset.

Top module: `sensor_cmd_ctrl`

## Requirements
- R1: After reset every configuration register reads zero, no action pulse or tx_valid is raised, and the interpreter waits for an opcode.
- R2: When an accepted opcode byte is seen in cycle N, exactly one pulse is raised in cycle N+1 and only in that cycle: 0x1B gives act_reset, 0x08 gives act_start, 0x10 gives act_sample, 0x02 gives act_read, and 0x19 gives act_abort.
- R3: Opcode 0x12 raises act_sample and act_read together in one cycle. Opcode 0x16 raises act_sample, act_read and act_start together in one cycle.
- R4: Any opcode byte that is not listed in R2 or R3 and whose top three bits are neither 010 nor 011 raises no pulse and no tx_valid. The byte after it is again decoded as an opcode.
- R5: A byte 010aaaaa makes the next accepted byte the write data for address aaaaa (bits 4:0). The new value shows on the register outputs in the cycle after the data byte. Neither byte raises a pulse.
- R6: Address 2z holds the 8-bit offset of zone z and address 2z+1 holds the gain of zone z, for zones 0 to 2 (left, center, right). A gain keeps only the low five bits of the write data. Address 0x1F holds the 8-bit mode register.
- R7: Writes to any other address change no register, and reads of any other address return 0x00.
- R8: A byte 011aaaaa accepted in cycle N raises tx_valid for the single cycle N+4, with tx_byte equal to the register value. Bit 0 of tx_byte is the register's LSB, which is sent first.
- R9: An interface-reset pulse forces the interpreter back to waiting for an opcode, which drops a pending write. A byte presented in the same cycle as interface reset is discarded.
- R10: Three consecutive 0x1B bytes, sent from either state, leave the interpreter waiting for an opcode, and at least the last two of them raise act_reset.
- R11: The sleep output equals mode bit 4. Setting it leaves command decoding and pulse generation unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| ifc_reset | input | 1 | Interface reset (break seen by receiver) |
| act_reset | output | 1 | Main reset pulse |
| act_start | output | 1 | Start integration pulse |
| act_sample | output | 1 | Sample-and-hold pulse |
| act_read | output | 1 | Pixel readout pulse |
| act_abort | output | 1 | Abort readout pulse |
| tx_valid | output | 1 | Register read value ready for transmitter |
| tx_byte | output | 8 | Register read value, bit 0 sent first |
| zone_offset | output | 24 | Zone offsets, zone z at bits 8z+7:8z |
| zone_gain | output | 15 | Zone gains, zone z at bits 5z+4:5z |
| mode_reg | output | 8 | Mode register |
| sleep | output | 1 | Sleep request, mode bit 4 |

## Verification
If the interpreter is left in ST_WDATA when it should not be, the next opcode is taken as write data. That shows at once, in the cycle after that byte: the expected pulse is missing and a register output changes. The whole opcode sweep sends bytes back to back, so one wrong transition hides the pulse of the byte right after it. A corrupted read capture or a delay line of the wrong length shows four cycles after the read opcode, as a tx_valid in the wrong cycle or a wrong tx_byte.

// File: rtl/sensor_cmd_pkg.sv
package sensor_cmd_pkg;

    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;

    localparam logic [BYTE_W-1:0] OP_MAIN_RESET  = 8'h1B;
    localparam logic [BYTE_W-1:0] OP_START_INT   = 8'h08;
    localparam logic [BYTE_W-1:0] OP_SAMPLE      = 8'h10;
    localparam logic [BYTE_W-1:0] OP_READ_PIX    = 8'h02;
    localparam logic [BYTE_W-1:0] OP_ABORT       = 8'h19;
    localparam logic [BYTE_W-1:0] OP_SAMPLE_READ = 8'h12;
    localparam logic [BYTE_W-1:0] OP_CYCLE       = 8'h16;

    localparam logic [2:0] PFX_REG_WRITE = 3'b010;
    localparam logic [2:0] PFX_REG_READ  = 3'b011;

    localparam logic [ADDR_W-1:0] ADDR_MODE = 5'h1F;
    localparam int SLEEP_BIT = 4;

    typedef enum logic {
        ST_OPCODE,
        ST_WDATA
    } cmd_state_e;

    typedef enum logic [3:0] {
        CK_NONE,
        CK_RESET,
        CK_START,
        CK_SAMPLE,
        CK_READ,
        CK_ABORT,
        CK_SAMPLE_READ,
        CK_CYCLE,
        CK_WRITE,
        CK_REGREAD
    } cmd_kind_e;

    typedef struct packed {
        logic main_reset;
        logic start;
        logic sample;
        logic read;
        logic abort;
    } act_pulse_t;

    function automatic cmd_kind_e classify(input logic [BYTE_W-1:0] b);
        cmd_kind_e k;
        if (b[7:5] == PFX_REG_WRITE) begin
            k = CK_WRITE;
        end else if (b[7:5] == PFX_REG_READ) begin
            k = CK_REGREAD;
        end else begin
            case (b)
                OP_MAIN_RESET:  k = CK_RESET;
                OP_START_INT:   k = CK_START;
                OP_SAMPLE:      k = CK_SAMPLE;
                OP_READ_PIX:    k = CK_READ;
                OP_ABORT:       k = CK_ABORT;
                OP_SAMPLE_READ: k = CK_SAMPLE_READ;
                OP_CYCLE:       k = CK_CYCLE;
                default:        k = CK_NONE;
            endcase
        end
        return k;
    endfunction

endpackage

// File: rtl/cmd_decoder.sv
module cmd_decoder
    import sensor_cmd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rx_valid,
    input  logic [BYTE_W-1:0]     rx_byte,
    input  logic                  ifc_reset,
    output cmd_state_e            state,
    output act_pulse_t            pulses,
    output logic                  wr_en,
    output logic [ADDR_W-1:0]     wr_addr,
    output logic [BYTE_W-1:0]     wr_data,
    output logic                  rd_req,
    output logic [ADDR_W-1:0]     rd_addr
);

    cmd_state_e        state_d;
    cmd_kind_e         kind;
    act_pulse_t        pulses_d;
    logic [ADDR_W-1:0] wr_addr_q;
    logic              capture_addr;

    // next state and decode
    always_comb begin
        kind         = classify(rx_byte);
        state_d      = state;
        pulses_d     = '0;
        wr_en        = 1'b0;
        rd_req       = 1'b0;
        capture_addr = 1'b0;
        wr_addr      = wr_addr_q;
        wr_data      = rx_byte;
        rd_addr      = rx_byte[ADDR_W-1:0];
        if (ifc_reset) begin
            state_d = ST_OPCODE;
        end else if (rx_valid) begin
            unique case (state)
                ST_OPCODE: begin
                    unique case (kind)
                        CK_WRITE: begin
                            state_d      = ST_WDATA;
                            capture_addr = 1'b1;
                        end
                        CK_REGREAD:     rd_req = 1'b1;
                        CK_RESET:       pulses_d.main_reset = 1'b1;
                        CK_START:       pulses_d.start = 1'b1;
                        CK_SAMPLE:      pulses_d.sample = 1'b1;
                        CK_READ:        pulses_d.read = 1'b1;
                        CK_ABORT:       pulses_d.abort = 1'b1;
                        CK_SAMPLE_READ: begin
                            pulses_d.sample = 1'b1;
                            pulses_d.read   = 1'b1;
                        end
                        CK_CYCLE: begin
                            pulses_d.sample = 1'b1;
                            pulses_d.read   = 1'b1;
                            pulses_d.start  = 1'b1;
                        end
                        default: ;
                    endcase
                end
                ST_WDATA: begin
                    wr_en   = 1'b1;
                    state_d = ST_OPCODE;
                end
                default: state_d = ST_OPCODE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_OPCODE;
            wr_addr_q <= '0;
        end else begin
            state <= state_d;
            if (capture_addr) begin
                wr_addr_q <= rx_byte[ADDR_W-1:0];
            end
        end
    end

    // registered action pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulses <= '0;
        end else begin
            pulses <= pulses_d;
        end
    end

endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile
    import sensor_cmd_pkg::*;
#(
    parameter int NUM_ZONES = 3,
    parameter int GAIN_W    = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [BYTE_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [BYTE_W-1:0]             rd_data,
    output logic [NUM_ZONES*BYTE_W-1:0]   zone_offset,
    output logic [NUM_ZONES*GAIN_W-1:0]   zone_gain,
    output logic [BYTE_W-1:0]             mode_reg
);

    localparam int GAIN_PAD = BYTE_W - GAIN_W;

    for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
        localparam logic [ADDR_W-1:0] OFF_ADDR  = ADDR_W'(2 * z);
        localparam logic [ADDR_W-1:0] GAIN_ADDR = ADDR_W'(2 * z + 1);
        logic [BYTE_W-1:0] off_q;
        logic [GAIN_W-1:0] gain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                off_q  <= '0;
                gain_q <= '0;
            end else if (wr_en) begin
                if (wr_addr == OFF_ADDR) begin
                    off_q <= wr_data;
                end
                if (wr_addr == GAIN_ADDR) begin
                    gain_q <= wr_data[GAIN_W-1:0];
                end
            end
        end

        assign zone_offset[z*BYTE_W +: BYTE_W] = off_q;
        assign zone_gain[z*GAIN_W +: GAIN_W]   = gain_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_reg <= '0;
        end else if (wr_en && wr_addr == ADDR_MODE) begin
            mode_reg <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int z = 0; z < NUM_ZONES; z++) begin
            if (rd_addr == ADDR_W'(2 * z)) begin
                rd_data = zone_offset[z*BYTE_W +: BYTE_W];
            end
            if (rd_addr == ADDR_W'(2 * z + 1)) begin
                rd_data = {{GAIN_PAD{1'b0}}, zone_gain[z*GAIN_W +: GAIN_W]};
            end
        end
        if (rd_addr == ADDR_MODE) begin
            rd_data = mode_reg;
        end
    end

endmodule

// File: rtl/rd_return_pipe.sv
module rd_return_pipe
    import sensor_cmd_pkg::*;
#(
    parameter int RD_DELAY = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic [BYTE_W-1:0] rd_value,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte
);

    logic [RD_DELAY-1:0] vld_q;
    logic [BYTE_W-1:0]   dat_q [RD_DELAY];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
            for (int i = 0; i < RD_DELAY; i++) begin
                dat_q[i] <= '0;
            end
        end else begin
            vld_q[0] <= rd_req;
            dat_q[0] <= rd_value;
            for (int i = 1; i < RD_DELAY; i++) begin
                vld_q[i] <= vld_q[i-1];
                dat_q[i] <= dat_q[i-1];
            end
        end
    end

    assign tx_valid = vld_q[RD_DELAY-1];
    assign tx_byte  = dat_q[RD_DELAY-1];

endmodule

// File: rtl/sensor_cmd_ctrl.sv
module sensor_cmd_ctrl
    import sensor_cmd_pkg::*;
#(
    parameter int NUM_ZONES = 3,
    parameter int GAIN_W    = 5,
    parameter int RD_DELAY  = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        rx_valid,
    input  logic [7:0]                  rx_byte,
    input  logic                        ifc_reset,
    output logic                        act_reset,
    output logic                        act_start,
    output logic                        act_sample,
    output logic                        act_read,
    output logic                        act_abort,
    output logic                        tx_valid,
    output logic [7:0]                  tx_byte,
    output logic [NUM_ZONES*8-1:0]      zone_offset,
    output logic [NUM_ZONES*GAIN_W-1:0] zone_gain,
    output logic [7:0]                  mode_reg,
    output logic                        sleep
);

    cmd_state_e        cmd_state;
    act_pulse_t        pulses;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [BYTE_W-1:0] wr_data;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic [BYTE_W-1:0] rd_data;

    cmd_decoder u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .ifc_reset (ifc_reset),
        .state     (cmd_state),
        .pulses    (pulses),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_req    (rd_req),
        .rd_addr   (rd_addr)
    );

    cfg_regfile #(
        .NUM_ZONES (NUM_ZONES),
        .GAIN_W    (GAIN_W)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .zone_offset (zone_offset),
        .zone_gain   (zone_gain),
        .mode_reg    (mode_reg)
    );

    rd_return_pipe #(
        .RD_DELAY (RD_DELAY)
    ) u_ret (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_req   (rd_req),
        .rd_value (rd_data),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte)
    );

    assign act_reset  = pulses.main_reset;
    assign act_start  = pulses.start;
    assign act_sample = pulses.sample;
    assign act_read   = pulses.read;
    assign act_abort  = pulses.abort;
    assign sleep      = mode_reg[SLEEP_BIT];

endmodule

// File: rtl/sensor_cmd_ctrl_chk.sv
module sensor_cmd_ctrl_chk
    import sensor_cmd_pkg::*;
#(
    parameter int NUM_ZONES = 3,
    parameter int GAIN_W    = 5
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        rx_valid,
    input logic [7:0]                  rx_byte,
    input logic                        ifc_reset,
    input logic                        act_reset,
    input logic                        act_start,
    input logic                        act_sample,
    input logic                        act_read,
    input logic                        act_abort,
    input logic [NUM_ZONES*GAIN_W-1:0] zone_gain,
    input logic                        sleep,
    input cmd_state_e                  cmd_state
);

    logic any_act;
    assign any_act = act_reset | act_start | act_sample | act_read | act_abort;

    // R2
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_start && !act_sample) |-> ($past(rx_valid) && $past(rx_byte) == 8'h08));

    // R2
    abort_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_abort |-> !(act_reset || act_start || act_sample || act_read));

    // R3
    cycle_macro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_start && act_sample) |-> (act_read && $past(rx_byte) == 8'h16));

    // R9
    ifc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ifc_reset) |-> (cmd_state == ST_OPCODE && !any_act));

    // R5
    gain_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(zone_gain) |-> ($past(cmd_state) == ST_WDATA && $past(rx_valid) && !$past(ifc_reset)));

    // R11
    sleep_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sleep) |-> ($past(cmd_state) == ST_WDATA && $past(rx_valid)));

endmodule

bind sensor_cmd_ctrl sensor_cmd_ctrl_chk #(
    .NUM_ZONES (NUM_ZONES),
    .GAIN_W    (GAIN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .rx_byte    (rx_byte),
    .ifc_reset  (ifc_reset),
    .act_reset  (act_reset),
    .act_start  (act_start),
    .act_sample (act_sample),
    .act_read   (act_read),
    .act_abort  (act_abort),
    .zone_gain  (zone_gain),
    .sleep      (sleep),
    .cmd_state  (cmd_state)
);

// File: tb/tb_sensor_cmd_ctrl.sv
module tb_sensor_cmd_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        ifc_reset = 1'b0;
    logic        act_reset, act_start, act_sample, act_read, act_abort;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic [23:0] zone_offset;
    logic [14:0] zone_gain;
    logic [7:0]  mode_reg;
    logic        sleep;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] shadow [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    sensor_cmd_ctrl dut (
        .clk (clk), .rst_n (rst_n), .rx_valid (rx_valid), .rx_byte (rx_byte),
        .ifc_reset (ifc_reset), .act_reset (act_reset), .act_start (act_start),
        .act_sample (act_sample), .act_read (act_read), .act_abort (act_abort),
        .tx_valid (tx_valid), .tx_byte (tx_byte), .zone_offset (zone_offset),
        .zone_gain (zone_gain), .mode_reg (mode_reg), .sleep (sleep)
    );

    function automatic logic [4:0] acts();
        return {act_reset, act_start, act_sample, act_read, act_abort};
    endfunction

    // expected {reset,start,sample,read,abort} for an opcode byte
    function automatic logic [4:0] exp_act(input logic [7:0] b);
        case (b)
            8'h1B:   return 5'b10000;
            8'h08:   return 5'b01000;
            8'h10:   return 5'b00100;
            8'h02:   return 5'b00010;
            8'h19:   return 5'b00001;
            8'h12:   return 5'b00110;
            8'h16:   return 5'b01110;
            default: return 5'b00000;
        endcase
    endfunction

    function automatic logic [46:0] exp_regs();
        return {shadow[31],
                shadow[5][4:0], shadow[3][4:0], shadow[1][4:0],
                shadow[4], shadow[2], shadow[0]};
    endfunction

    function automatic logic [46:0] got_regs();
        return {mode_reg, zone_gain, zone_offset};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic model_write(input logic [4:0] a, input logic [7:0] d);
        if (a < 5'd6 || a == 5'h1F) shadow[a] = (a < 5'd6 && a[0]) ? (d & 8'h1F) : d;
    endtask

    task automatic reg_write(input logic [4:0] a, input logic [7:0] d);
        send_byte({3'b010, a});
        check(acts() == 5'b0, "R5 write opcode pulses", acts(), 0);
        send_byte(d);
        model_write(a, d);
        check(acts() == 5'b0 && got_regs() == exp_regs(), "R5 R6 R7 write effect",
              {acts(), got_regs()}, exp_regs());
    endtask

    task automatic reg_read(input logic [4:0] a);
        bit early;
        early = 1'b0;
        send_byte({3'b011, a});
        for (int k = 1; k < 4; k++) begin
            if (tx_valid) early = 1'b1;
            @(negedge clk);
        end
        check(!early && tx_valid && tx_byte == shadow[a], "R8 R7 read value and timing",
              {early, tx_valid, tx_byte}, {2'b01, shadow[a]});
        @(negedge clk);
        check(!tx_valid, "R8 tx_valid single cycle", tx_valid, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) shadow[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check(acts() == 5'b0 && !tx_valid && got_regs() == '0 && !sleep, "R1 reset state",
              {acts(), tx_valid, got_regs()}, 0);
        reg_read(5'h00);
        reg_read(5'h1F);

        // R2 R3 R4 opcode sweep, bytes back to back
        for (int b = 0; b < 256; b++) begin
            logic [7:0] bb;
            bb = 8'(b);
            if (bb[7:6] != 2'b01) begin
                @(negedge clk);
                rx_valid = 1'b1;
                rx_byte  = bb;
                @(negedge clk);
                rx_valid = 1'b0;
                check(acts() == exp_act(bb) && !tx_valid, "R2 R3 R4 opcode pulse",
                      {bb, acts()}, {bb, exp_act(bb)});
                @(negedge clk);
                check(acts() == 5'b0, "R2 pulse one cycle", acts(), 0);
            end
        end

        // R5 R6 R7 R8 full address sweep, two patterns
        for (int a = 0; a < 32; a++) reg_write(5'(a), 8'((a * 53 + 29) & 255));
        for (int a = 0; a < 32; a++) reg_read(5'(a));
        for (int a = 0; a < 32; a++) reg_write(5'(a), ~8'((a * 53 + 29) & 255));
        for (int a = 0; a < 32; a++) reg_read(5'(a));
        reg_write(5'h1F, 8'h00);

        // R9 break drops pending write
        send_byte(8'h42);
        @(negedge clk);
        ifc_reset = 1'b1;
        @(negedge clk);
        ifc_reset = 1'b0;
        send_byte(8'h08);
        check(acts() == 5'b01000 && got_regs() == exp_regs(), "R9 break clears pending write",
              {acts(), got_regs()}, {5'b01000, exp_regs()});

        // R9 byte in same cycle as break is discarded
        send_byte(8'h40);
        @(negedge clk);
        ifc_reset = 1'b1;
        rx_valid  = 1'b1;
        rx_byte   = 8'h1B;
        @(negedge clk);
        ifc_reset = 1'b0;
        rx_valid  = 1'b0;
        check(acts() == 5'b0 && got_regs() == exp_regs(), "R9 concurrent byte dropped",
              {acts(), got_regs()}, exp_regs());
        send_byte(8'h10);
        check(acts() == 5'b00100, "R9 opcode state after break", acts(), 5'b00100);

        // R10 three resets resynchronise from pending write
        begin
            int resets;
            resets = 0;
            send_byte(8'h43);
            for (int k = 0; k < 3; k++) begin
                send_byte(8'h1B);
                if (act_reset) resets++;
            end
            model_write(5'h03, 8'h1B);
            check(resets == 2 && got_regs() == exp_regs(), "R10 triple reset count",
                  resets, 2);
            send_byte(8'h08);
            check(acts() == 5'b01000, "R10 opcode state after triple reset", acts(), 5'b01000);
        end

        // R11 sleep does not alter decoding
        reg_write(5'h1F, 8'h10);
        check(sleep == 1'b1, "R11 sleep set", sleep, 1);
        send_byte(8'h16);
        check(acts() == 5'b01110, "R11 macro while asleep", acts(), 5'b01110);
        send_byte(8'h19);
        check(acts() == 5'b00001, "R11 abort while asleep", acts(), 5'b00001);
        reg_read(5'h1F);
        reg_write(5'h1F, 8'h00);
        check(sleep == 1'b0, "R11 sleep cleared", sleep, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule